// File: doc/BRIEF.md
# Presettable Down Counter Stage with Terminal Count

This block is a binary down counter, eight bits wide by default, that loses one count on every rising clock edge while its enable is active. It can be forced to all ones or loaded with a parallel word at any moment through two level-sensitive controls. It can also take the same word at the next clock edge through a synchronous load. A hold input freezes the count. All of these controls are active low.

The terminal count output is active low. It is asserted while the count is zero and the enable is active. It is decoded combinationally, so raising the enable clears it at once. Wiring each stage's terminal count into the next stage's enable chains stages on a shared clock into a wider counter. Counting down from zero wraps to all ones, so a free-running stage repeats every 256 clocks.

Top module: `dcnt_stage`

## Requirements
- R1: While `mr_n` is low, `count` is 255 (all ones) immediately, whatever the clock and all other inputs do; it has the highest priority.
- R2: While `mr_n` is high and `aload_n` is low, `count` equals `load_val` immediately, regardless of `sload_n`, `te_n` and the clock.
- R3: With both level controls high and `sload_n` low, `count` takes `load_val` at the next rising edge even when `te_n` is high.
- R4: With `mr_n`, `aload_n` and `sload_n` high and `te_n` low, `count` decreases by one at each rising edge.
- R5: With the level controls and `sload_n` high, a high `te_n` leaves `count` unchanged across clock edges.
- R6: `tc_n` is low exactly when `count` is zero and `te_n` is low. It follows `te_n` without waiting for a clock edge.
- R7: A decrement from zero gives 255, so a free-running stage returns to the same value after 256 edges.
- R8: `load_val` is one unsigned binary word: bit 7 is the most significant and bit 0 the least (value = sum of bit i times 2^i).
- R9: Two stages sharing the clock, with the first stage's `tc_n` driving the second stage's `te_n`, count down as one 16-bit counter (second stage = upper byte). Starting from all ones, they pass through all 65536 values.
- R10: After `mr_n` or `aload_n` returns high, synchronous operation resumes at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| mr_n | input | 1 | Level-sensitive force to all ones, active low |
| aload_n | input | 1 | Level-sensitive parallel load, active low |
| sload_n | input | 1 | Parallel load at next rising edge, active low |
| te_n | input | 1 | Count enable, active low; high holds the count |
| load_val | input | WIDTH | Parallel load word, bit WIDTH-1 most significant |
| count | output | WIDTH | Current count |
| tc_n | output | 1 | Terminal count, active low |

## Verification
The assertions assume that `load_val` stays constant while `aload_n` is low, because the level-sensitive load captures the word when it is asserted. They also assume that `mr_n` is never released while `aload_n` is still low. The stimulus changes every input only on the falling clock edge. It alters `load_val` only in steps where `aload_n` was high in the previous step, and it forces `aload_n` high in any step that releases `mr_n`. With every control held for a full cycle, what a clocked property samples at a rising edge is what the register saw.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic [1:0] {
    MODE_DEC  = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_JAM  = 2'd2
  } sync_mode_e;
endpackage

// File: rtl/dcnt_mode_sel.sv
module dcnt_mode_sel
  import dcnt_pkg::*;
(
  input  logic       sload_n,
  input  logic       te_n,
  output sync_mode_e mode
);
  // Synchronous load outranks the hold input.
  always_comb begin
    if (!sload_n)   mode = MODE_JAM;
    else if (te_n)  mode = MODE_HOLD;
    else            mode = MODE_DEC;
  end
endmodule

// File: rtl/dcnt_next.sv
module dcnt_next
  import dcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] load_val,
  input  sync_mode_e       mode,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // Modular subtraction gives the wrap from zero to all ones.
  always_comb begin
    case (mode)
      MODE_JAM:  nxt = load_val;
      MODE_HOLD: nxt = cur;
      default:   nxt = cur - ONE;
    endcase
  end
endmodule

// File: rtl/dcnt_zero_det.sv
module dcnt_zero_det #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             te_n,
  output logic             tc_n
);
  logic is_zero;
  assign is_zero = ~|cur;
  assign tc_n    = ~(is_zero & ~te_n);
endmodule

// File: rtl/dcnt_stage.sv
module dcnt_stage
  import dcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             mr_n,
  input  logic             aload_n,
  input  logic             sload_n,
  input  logic             te_n,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  sync_mode_e       mode;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  dcnt_mode_sel u_mode (
    .sload_n (sload_n),
    .te_n    (te_n),
    .mode    (mode)
  );

  dcnt_next #(.WIDTH(WIDTH)) u_next (
    .cur      (cnt_q),
    .load_val (load_val),
    .mode     (mode),
    .nxt      (cnt_d)
  );

  // Level-sensitive terms: force to all ones first, then parallel load.
  always_ff @(posedge clk or negedge mr_n or negedge aload_n) begin
    if (!mr_n)         cnt_q <= ALL_ONES;
    else if (!aload_n) cnt_q <= load_val;
    else               cnt_q <= cnt_d;
  end

  dcnt_zero_det #(.WIDTH(WIDTH)) u_zero (
    .cur  (cnt_q),
    .te_n (te_n),
    .tc_n (tc_n)
  );

  assign count = cnt_q;
endmodule

// File: rtl/dcnt_stage_chk.sv
module dcnt_stage_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             mr_n,
  input logic             aload_n,
  input logic             sload_n,
  input logic             te_n,
  input logic [WIDTH-1:0] load_val,
  input logic [WIDTH-1:0] count,
  input logic             tc_n
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  AST_FORCE_ONES: assert property (@(posedge clk)
    !mr_n |-> count == ALL_ONES); // R1

  AST_ALOAD_TRACK: assert property (@(posedge clk)
    (mr_n && !aload_n) |-> count == load_val); // R2

  AST_SLOAD_EDGE: assert property (@(posedge clk) disable iff (!mr_n || !aload_n)
    !sload_n |=> count == $past(load_val)); // R3

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!mr_n || !aload_n)
    (sload_n && !te_n) |=> count == $past(count) - ONE); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!mr_n || !aload_n)
    (sload_n && te_n) |=> $stable(count)); // R5

  AST_TC_GATED: assert property (@(posedge clk)
    te_n |-> tc_n); // R6

  AST_TC_NONZERO: assert property (@(posedge clk)
    (count != '0) |-> tc_n); // R6

  AST_WRAP_ONES: assert property (@(posedge clk) disable iff (!mr_n || !aload_n)
    (sload_n && !te_n && count == '0) |=> count == ALL_ONES); // R7
endmodule

bind dcnt_stage dcnt_stage_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .mr_n     (mr_n),
  .aload_n  (aload_n),
  .sload_n  (sload_n),
  .te_n     (te_n),
  .load_val (load_val),
  .count    (count),
  .tc_n     (tc_n)
);

// File: tb/dcnt_stage_tb_top.sv
`timescale 1ns/1ps
module dcnt_stage_tb_top;
  logic       clk = 1'b0;
  logic       mr_n = 1'b1;
  logic       aload_n = 1'b1;
  logic       sload_n = 1'b1;
  logic       te_n = 1'b1;
  logic [7:0] lv_lo = 8'd0;
  logic [7:0] lv_hi = 8'd0;
  logic [7:0] cnt_lo, cnt_hi;
  logic       tc_lo_n, tc_hi_n;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 0;

  int ref_lo = 0;
  int ref_hi = 0;

  always #2.5 clk = ~clk;

  dcnt_stage #(.WIDTH(8)) dut_i (
    .clk(clk), .mr_n(mr_n), .aload_n(aload_n), .sload_n(sload_n), .te_n(te_n),
    .load_val(lv_lo), .count(cnt_lo), .tc_n(tc_lo_n)
  );

  dcnt_stage #(.WIDTH(8)) dut_hi_i (
    .clk(clk), .mr_n(mr_n), .aload_n(aload_n), .sload_n(sload_n), .te_n(tc_lo_n),
    .load_val(lv_hi), .count(cnt_hi), .tc_n(tc_hi_n)
  );

  function automatic bit exp_tc_lo_n();
    return !(ref_lo == 0 && !te_n);
  endfunction

  function automatic bit exp_tc_hi_n();
    return !(ref_hi == 0 && !exp_tc_lo_n());
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (cnt_lo !== ref_lo[7:0] || cnt_hi !== ref_hi[7:0] ||
        tc_lo_n !== exp_tc_lo_n() || tc_hi_n !== exp_tc_hi_n()) begin
      misses++;
      $display("FAIL %s: got hi=%0d lo=%0d tc_hi=%0b tc_lo=%0b exp hi=%0d lo=%0d tc_hi=%0b tc_lo=%0b",
               tag, cnt_hi, cnt_lo, tc_hi_n, tc_lo_n,
               ref_hi, ref_lo, exp_tc_hi_n(), exp_tc_lo_n());
    end
  endtask

  // One clock step: drive on falling edge, check level terms at once,
  // then check the synchronous result just after the rising edge.
  task automatic step(input bit mr, input bit al, input bit sl, input bit te,
                      input logic [7:0] lo, input logic [7:0] hi, input string tag);
    bit tc0;
    @(negedge clk);
    lv_lo = lo; lv_hi = hi;
    te_n = te; sload_n = sl; aload_n = al; mr_n = mr;
    #1;
    if (!mr) begin ref_lo = 255; ref_hi = 255; end
    else if (!al) begin ref_lo = lo; ref_hi = hi; end
    if (!mr || !al) compare(tag);
    @(posedge clk);
    if (mr && al) begin
      tc0 = !(ref_lo == 0 && !te);
      if (!sl) begin ref_lo = lo; ref_hi = hi; end
      else begin
        if (!te)  ref_lo = (ref_lo + 255) % 256;
        if (!tc0) ref_hi = (ref_hi + 255) % 256;
      end
    end
    #1;
    compare(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 199000 && !done) begin
      misses++;
      $display("FAIL watchdog: got %0d cycles exp completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    bit prev_mr, prev_al;
    #1 mr_n = 1'b0;
    // R1: force to all ones beats both loads and the clock
    step(0, 0, 0, 0, 8'h12, 8'h34, "R1");
    step(0, 1, 0, 1, 8'h00, 8'h00, "R1");
    step(0, 1, 1, 0, 8'h00, 8'h00, "R1");
    // R10 R4: release, then decrement from the next edge
    step(1, 1, 1, 0, 8'h00, 8'h00, "R10");
    step(1, 1, 1, 0, 8'h00, 8'h00, "R4");
    step(1, 1, 1, 0, 8'h00, 8'h00, "R4");
    // R2: parallel load at once, sync load and hold ignored
    step(1, 0, 0, 1, 8'h12, 8'h34, "R2");
    step(1, 0, 1, 0, 8'h12, 8'h34, "R2");
    step(1, 1, 1, 0, 8'h12, 8'h34, "R10");
    // R3 R8: sync load with hold active, asymmetric bit patterns
    step(1, 1, 0, 1, 8'hA5, 8'h01, "R3");
    step(1, 1, 0, 1, 8'h80, 8'h7F, "R8");
    // R5: hold
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 8'h00, 8'h00, "R5");
    // R6 R9: lower byte reaches zero and borrows into upper byte
    step(1, 1, 0, 1, 8'h03, 8'h01, "R3");
    for (int i = 0; i < 6; i++) step(1, 1, 1, 0, 8'h03, 8'h01, "R6");
    // R6: combinational gating of terminal count by the enable
    step(1, 1, 0, 1, 8'h00, 8'h00, "R3");
    @(negedge clk); te_n = 1'b0; #0.5;
    compare("R6");
    te_n = 1'b1; #0.5;
    compare("R6");
    // R7 R9: full free-running 16-bit sequence from all ones
    step(0, 1, 1, 1, 8'h00, 8'h00, "R1");
    for (int i = 0; i < 65540; i++) step(1, 1, 1, 0, 8'h00, 8'h00, "R9");
    // R7 single stage wrap period: 256 edges return lower byte
    step(1, 1, 0, 1, 8'h05, 8'h09, "R3");
    for (int i = 0; i < 256; i++) step(1, 1, 1, 0, 8'h05, 8'h09, "R7");
    // Mixed control combinations within the input rules
    prev_mr = 1; prev_al = 1;
    for (int i = 0; i < 4000; i++) begin
      bit mr, al, sl, te;
      logic [7:0] lo, hi;
      mr = ($urandom_range(0, 15) != 0);
      al = ($urandom_range(0, 9) != 0);
      sl = ($urandom_range(0, 5) != 0);
      te = ($urandom_range(0, 3) == 0);
      if (!prev_mr && mr) al = 1;
      if (!prev_al) begin lo = lv_lo; hi = lv_hi; end
      else begin lo = 8'($urandom); hi = 8'($urandom); end
      step(mr, al, sl, te, lo, hi,
           !mr ? "R1" : !al ? "R2" : !sl ? "R3" : te ? "R5" : "R4");
      prev_mr = mr; prev_al = al;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule